// File: doc/BRIEF.md
# Edge-Sensing Register-Mapped GPIO Port

This block is a 32-pin general-purpose I/O port sitting on a plain register bus with an address, a write strobe, write data and read data. Each pin can be an input or an output. An output drives either push-pull or open-drain, and the pad's tristate control comes out as a per-pin output-enable signal. Every input passes through a two-flop synchroniser and is then watched for transitions.

A detected transition sets a sticky event bit. Software clears event bits by writing ones to them. Each pin can sense either falling transitions only or both directions. A mask register selects which events may reach the single interrupt line. The interrupt is high while any event is both pending and enabled.

The register bit order is reversed with respect to pin numbers, so pin 0 lives in the most significant bit. Reading the data register gives the stored value for output pins and the synchronised pad for input pins.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset every register (direction, open-drain, data, event, mask, edge control) reads 0, the interrupt is low and no pad output-enable is active.
- R2: Word offsets are direction 0x00, open-drain 0x04, data 0x08, event 0x0C, mask 0x10 and edge control 0x14. Pin n occupies bit 31-n of every register. Read data shows the addressed register one clock after the address is presented. Any other offset reads 0.
- R3: A direction bit of 1 makes the pin an output and a 0 makes it an input. An output pin that is not open-drain has its output-enable high and drives its data bit. An input pin never has its output-enable high.
- R4: An output pin whose open-drain bit is 1 drives 0 with output-enable high when its data bit is 0, and is released (output-enable low, pad output 0) when its data bit is 1.
- R5: A data register read returns, per bit, the stored data on output pins and the synchronised pad value on input pins.
- R6: A pad change presented before clock edge k becomes a pending event at edge k+2. No event bit becomes set without a detected transition.
- R7: An edge-control bit of 1 records only falling transitions on that pin. A bit of 0 records both rising and falling transitions.
- R8: Writing a 1 to an event bit clears it. Writing a 0 leaves it unchanged. Writing all ones clears every pending event.
- R9: The interrupt output is high exactly when some bit is set in both the event register and the mask register, where a mask bit of 1 enables that pin.
- R10: When a new transition and a clearing write hit the same event bit in the same cycle, the bit remains set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad input levels, index = pin number |
| pad_out | output | 32 | Pad output levels, index = pin number |
| pad_oe | output | 32 | Pad output enables, index = pin number |
| irq | output | 1 | Interrupt request |

## Verification
The bench counts clock edges from a pad change to the interrupt rising. A design with one flop too few or too many in the input path misses the exact cycle. It aims a clearing write at the same edge where a new transition lands on that bit. A design that lets the clear win loses the event, and one that clears the whole register drops another pending pin. It drives rising pulses on a falling-only pin, which a design with an inverted edge-control sense would record. It also checks pad numbering against register bits at both ends of the word and compares open-drain release against push-pull drive, so a port with a non-reversed bit order, or one that drives a high level in open-drain mode, shows a mismatch at the pads.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
    localparam int unsigned GPIO_PINS   = 32;
    localparam int unsigned GPIO_ADDR_W = 5;

    typedef enum logic [2:0] {
        SEL_DIR = 3'd0,
        SEL_OD  = 3'd1,
        SEL_DAT = 3'd2,
        SEL_EVT = 3'd3,
        SEL_MSK = 3'd4,
        SEL_CTL = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] raw_i,
    output logic [PINS-1:0] sync_o,
    output logic [PINS-1:0] any_o,
    output logic [PINS-1:0] fall_o
);
    typedef struct packed {
        logic [PINS-1:0] meta;
        logic [PINS-1:0] cur;
        logic [PINS-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = raw_i;
        st_d.cur  = st_q.meta;
        st_d.prev = st_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.cur;
    assign any_o  = st_q.cur ^ st_q.prev;
    assign fall_o = st_q.prev & ~st_q.cur;
endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank #(
    parameter int unsigned PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] set_i,
    input  logic [PINS-1:0] clr_i,
    output logic [PINS-1:0] evt_o
);
    logic [PINS-1:0] evt_d, evt_q;

    always_comb begin
        // a fresh transition overrides a clear in the same cycle
        evt_d = (evt_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= evt_d;
    end

    assign evt_o = evt_q;

    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((evt_q | $past(clr_i)) & $past(evt_q)) == $past(evt_q)); // R8
    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (evt_q & $past(set_i)) == $past(set_i)); // R10
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (evt_q & ~$past(evt_q) & ~$past(set_i)) == '0); // R6
endmodule

// File: rtl/gpio_pad_drv.sv
module gpio_pad_drv #(
    parameter int unsigned PINS = 32
) (
    input  logic [PINS-1:0] dir_i,
    input  logic [PINS-1:0] od_i,
    input  logic [PINS-1:0] dat_i,
    output logic [PINS-1:0] pad_out_o,
    output logic [PINS-1:0] pad_oe_o
);
    // register bit b belongs to pin PINS-1-b
    for (genvar n = 0; n < PINS; n++) begin : g_pin
        localparam int unsigned B = PINS - 1 - n;
        assign pad_out_o[n] = od_i[B] ? 1'b0 : dat_i[B];
        assign pad_oe_o[n]  = dir_i[B] & (~od_i[B] | ~dat_i[B]);
    end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_edge_pkg::*;
#(
    parameter int unsigned PINS   = GPIO_PINS,
    parameter int unsigned ADDR_W = GPIO_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    output logic              irq
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    typedef struct packed {
        logic [PINS-1:0] dir;
        logic [PINS-1:0] od;
        logic [PINS-1:0] dat;
        logic [PINS-1:0] msk;
        logic [PINS-1:0] ctl;
        logic [PINS-1:0] rdata;
    } port_regs_t;

    port_regs_t r_d, r_q;

    logic [IDX_W-1:0] idx;
    logic             word_ok;
    logic [PINS-1:0]  pad_in_b;
    logic [PINS-1:0]  sync_b, any_b, fall_b;
    logic [PINS-1:0]  evt_set, evt_clr, evt_q;

    assign idx     = bus_addr[ADDR_W-1:2];
    assign word_ok = (bus_addr[1:0] == 2'b00);

    // bring pads into register bit order
    for (genvar n = 0; n < PINS; n++) begin : g_rev
        assign pad_in_b[PINS-1-n] = pad_in[n];
    end

    gpio_in_sync #(.PINS(PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pad_in_b),
        .sync_o (sync_b),
        .any_o  (any_b),
        .fall_o (fall_b)
    );

    assign evt_set = (r_q.ctl & fall_b) | (~r_q.ctl & any_b);
    assign evt_clr = (bus_we && word_ok && idx == IDX_W'(SEL_EVT)) ? bus_wdata : '0;

    gpio_evt_bank #(.PINS(PINS)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_set),
        .clr_i (evt_clr),
        .evt_o (evt_q)
    );

    gpio_pad_drv #(.PINS(PINS)) u_drv (
        .dir_i     (r_q.dir),
        .od_i      (r_q.od),
        .dat_i     (r_q.dat),
        .pad_out_o (pad_out),
        .pad_oe_o  (pad_oe)
    );

    always_comb begin
        r_d = r_q;
        if (bus_we && word_ok) begin
            case (idx)
                IDX_W'(SEL_DIR): r_d.dir = bus_wdata;
                IDX_W'(SEL_OD):  r_d.od  = bus_wdata;
                IDX_W'(SEL_DAT): r_d.dat = bus_wdata;
                IDX_W'(SEL_MSK): r_d.msk = bus_wdata;
                IDX_W'(SEL_CTL): r_d.ctl = bus_wdata;
                default: ;
            endcase
        end
        r_d.rdata = '0;
        if (word_ok) begin
            case (idx)
                IDX_W'(SEL_DIR): r_d.rdata = r_q.dir;
                IDX_W'(SEL_OD):  r_d.rdata = r_q.od;
                IDX_W'(SEL_DAT): r_d.rdata = (r_q.dat & r_q.dir) | (sync_b & ~r_q.dir);
                IDX_W'(SEL_EVT): r_d.rdata = evt_q;
                IDX_W'(SEL_MSK): r_d.rdata = r_q.msk;
                IDX_W'(SEL_CTL): r_d.rdata = r_q.ctl;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata = r_q.rdata;
    assign irq       = |(evt_q & r_q.msk);

    logic [PINS-1:0] dir_pin, od_pin;
    for (genvar n = 0; n < PINS; n++) begin : g_chk
        assign dir_pin[n] = r_q.dir[PINS-1-n];
        assign od_pin[n]  = r_q.od[PINS-1-n];
    end

    AST_IRQ_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> !irq); // R1
    AST_OE_ONLY_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~dir_pin) == '0); // R3
    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & od_pin) == '0); // R4
    AST_UNUSED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (idx > IDX_W'(SEL_CTL)) |=> bus_rdata == '0); // R2
endmodule

// File: tb/gpio_edge_port_bench.sv
module gpio_edge_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq;

    int total = 0;
    int bad   = 0;

    localparam logic [4:0] A_DIR = 5'h00, A_OD = 5'h04, A_DAT = 5'h08,
                           A_EVT = 5'h0C, A_MSK = 5'h10, A_CTL = 5'h14;

    always #5 clk = ~clk;

    gpio_edge_port u_gpio_edge_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    function automatic logic [31:0] pb(int n);
        return 32'h1 << (31 - n);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        @(posedge clk);
        #1 d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle_clear();
        idle(4);
        wr(A_EVT, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_DIR, v); chk("R1 dir", v, 0);
        rd(A_OD,  v); chk("R1 od", v, 0);
        rd(A_DAT, v); chk("R1 dat", v, 0);
        rd(A_EVT, v); chk("R1 evt", v, 0);
        rd(A_MSK, v); chk("R1 msk", v, 0);
        rd(A_CTL, v); chk("R1 ctl", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 oe", pad_oe, 0);
    endtask

    task automatic t_reg_map();
        logic [31:0] v;
        wr(A_DIR, pb(0) | pb(5));
        idle(1);
        chk("R2 R3 oe map", pad_oe, 32'h0000_0021);
        rd(A_DIR, v); chk("R2 dir rd", v, 32'h8400_0000);
        wr(A_MSK, 32'hA5A5_0F0F); rd(A_MSK, v); chk("R2 msk rd", v, 32'hA5A5_0F0F);
        wr(A_CTL, 32'h0F0F_A5A5); rd(A_CTL, v); chk("R2 ctl rd", v, 32'h0F0F_A5A5);
        wr(A_OD, 32'h1234_8765);  rd(A_OD, v);  chk("R2 od rd", v, 32'h1234_8765);
        rd(5'h18, v); chk("R2 unused", v, 0);
        // read latency: value appears one edge after the address
        @(negedge clk); bus_addr = A_MSK;
        chk("R2 latency old", bus_rdata, 0);
        @(posedge clk); #1 chk("R2 latency new", bus_rdata, 32'hA5A5_0F0F);
        wr(A_DIR, 0); wr(A_OD, 0); wr(A_MSK, 0); wr(A_CTL, 0);
    endtask

    task automatic t_push_pull();
        wr(A_DIR, 32'hFFFF_FFFF);
        wr(A_DAT, 32'h8000_0001);
        idle(1);
        chk("R3 pp out", pad_out, 32'h8000_0001);
        chk("R3 pp oe", pad_oe, 32'hFFFF_FFFF);
    endtask

    task automatic t_open_drain();
        wr(A_DIR, 32'hFFFF_FFFE);          // pin 31 input
        wr(A_DAT, pb(0) | pb(31));
        wr(A_OD, pb(0) | pb(1) | pb(31));
        idle(1);
        chk("R4 od released pin0", {31'd0, pad_oe[0]}, 0);
        chk("R4 od low pin1 oe", {31'd0, pad_oe[1]}, 1);
        chk("R4 od out", pad_out & 32'h8000_0003, 0);
        chk("R3 input no oe", {31'd0, pad_oe[31]}, 0);
        wr(A_OD, 0); wr(A_DIR, 0); wr(A_DAT, 0);
    endtask

    task automatic t_read_mux();
        logic [31:0] v;
        wr(A_DIR, 32'hFFFF_0000);
        wr(A_DAT, 32'h1234_5678);
        @(negedge clk); pad_in = 32'hFFFF_FFFF;
        idle(3);
        rd(A_DAT, v); chk("R5 mux hi", v, 32'h1234_FFFF);
        @(negedge clk); pad_in = 32'h0000_0000;
        idle(3);
        rd(A_DAT, v); chk("R5 mux lo", v, 32'h1234_0000);
        wr(A_DIR, 0); wr(A_DAT, 0);
        settle_clear();
    endtask

    task automatic t_edge_timing();
        logic [31:0] v;
        wr(A_MSK, pb(3));
        @(negedge clk); pad_in[3] = 1'b1;
        @(negedge clk); chk("R6 k", {31'd0, irq}, 0);
        @(negedge clk); chk("R6 k+1", {31'd0, irq}, 0);
        @(negedge clk); chk("R6 k+2 R9", {31'd0, irq}, 1);
        rd(A_EVT, v); chk("R6 rise evt", v, pb(3));
        wr(A_EVT, pb(3));
        rd(A_EVT, v); chk("R8 cleared", v, 0);
        chk("R9 irq low", {31'd0, irq}, 0);
        @(negedge clk); pad_in[3] = 1'b0;
        idle(4);
        rd(A_EVT, v); chk("R7 both fall", v, pb(3));
        wr(A_MSK, 0);
        settle_clear();
    endtask

    task automatic t_fall_only();
        logic [31:0] v;
        wr(A_CTL, pb(7));
        @(negedge clk); pad_in[7] = 1'b1;
        idle(4);
        rd(A_EVT, v); chk("R7 rise ignored", v, 0);
        @(negedge clk); pad_in[7] = 1'b0;
        idle(4);
        rd(A_EVT, v); chk("R7 fall seen", v, pb(7));
        wr(A_CTL, 0);
        settle_clear();
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        @(negedge clk); pad_in[2] = 1'b1; pad_in[9] = 1'b1;
        idle(4);
        rd(A_EVT, v); chk("R8 two pending", v, pb(2) | pb(9));
        wr(A_EVT, pb(2));
        rd(A_EVT, v); chk("R8 one cleared", v, pb(9));
        wr(A_EVT, 0);
        rd(A_EVT, v); chk("R8 zero no effect", v, pb(9));
        wr(A_EVT, 32'hFFFF_FFFF);
        rd(A_EVT, v); chk("R8 all cleared", v, 0);
        @(negedge clk); pad_in[2] = 1'b0; pad_in[9] = 1'b0;
        settle_clear();
    endtask

    task automatic t_irq_mask();
        @(negedge clk); pad_in[4] = 1'b1;
        idle(4);
        chk("R9 masked off", {31'd0, irq}, 0);
        wr(A_MSK, pb(5));
        idle(1);
        chk("R9 other pin", {31'd0, irq}, 0);
        wr(A_MSK, pb(4));
        idle(1);
        chk("R9 enabled", {31'd0, irq}, 1);
        wr(A_EVT, pb(4));
        idle(1);
        chk("R9 cleared", {31'd0, irq}, 0);
        wr(A_MSK, 0);
        @(negedge clk); pad_in[4] = 1'b0;
        settle_clear();
    endtask

    task automatic t_collision();
        logic [31:0] v;
        @(negedge clk); pad_in[10] = 1'b1;
        idle(4);
        @(negedge clk); pad_in[11] = 1'b1;     // before edge k
        @(negedge clk);                        // after k
        @(negedge clk);                        // after k+1: clear lands at k+2
        bus_addr = A_EVT; bus_wdata = pb(10) | pb(11); bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
        rd(A_EVT, v); chk("R10 edge wins", v, pb(11));
        @(negedge clk); pad_in[10] = 1'b0; pad_in[11] = 1'b0;
        settle_clear();
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_reg_map();
        t_push_pull();
        t_open_drain();
        t_read_mux();
        t_edge_timing();
        t_fall_only();
        t_w1c();
        t_irq_mask();
        t_collision();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule